// File: doc/BRIEF.md
# Redundant Input Sample Agreement Checker

This block gives two redundant processing channels one common view of an external input word. When the arbiter issues a sample request, the block captures the input once into a shared register. It drives that one captured value onto both channel ports and pulses a strobe so that both channels read it. Each channel then returns the word it read. The block compares the two returned words in place of a direct exchange between the channels.

When the two words match, the block emits the agreed word with a one-cycle valid pulse and goes idle again. When they differ, it captures the input again, pulses the strobe again and waits for a fresh pair of reports. A run of consecutive failed comparisons, five by default, raises a fail-safe trip. This bounds the retries so the exchange cannot loop forever. Once raised, the trip holds and the block ignores all further stimulus until reset.

During startup a self-test select input makes the capture take a test pattern word instead of the field input. The arbiter nominally issues one request every 10 ms. That cadence belongs to the arbiter and is not timed inside this block.

Top module: `dual_sample_agree`

## Requirements
- R1: Synchronous active-high reset clears both channel words to zero. It also drives `latch_stb`, `busy`, `agree_vld` and `safe_trip` low and clears the failure count.
- R2: A `sample_req` sampled high while idle captures `field_word` (when `selftest_en` is 0) into one register driving both `chan_a_word` and `chan_b_word`. After that edge `busy` is high and `latch_stb` is high for exactly one cycle.
- R3: With `selftest_en` at 1 when the capture happens, `selftest_word` is captured instead of `field_word`.
- R4: A `sample_req` while `busy` or tripped is ignored: the channel words stay unchanged and `latch_stb` stays low.
- R5: Channel reports are accepted only while `busy`. Only the first report from each channel after a capture counts, and the two may arrive in different cycles. The comparison happens at the edge after the one where the second report is held.
- R6: On a matching comparison, `agree_vld` is high for exactly one cycle after that edge with `agree_word` equal to the reported word. At the same time `busy` drops.
- R7: On a mismatching comparison that is not the last allowed one, the block recaptures the current input at the comparison edge. `latch_stb` pulses for one cycle, `busy` stays high and `agree_vld` stays low.
- R8: The fifth consecutive mismatching comparison (parameter MAX_FAILS) raises `safe_trip` after that edge with no recapture. From then on `busy` is low and `agree_vld` never rises.
- R9: `safe_trip` stays high, and requests and reports stay ignored, until reset clears it.
- R10: An agreement clears the failure count. Four mismatches followed by agreement, repeated twice, never trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_req | input | 1 | Sample request from the arbiter |
| selftest_en | input | 1 | Select the self-test word as the capture source |
| field_word | input | WORD_W | External input word |
| selftest_word | input | WORD_W | Self-test pattern word |
| chan_a_word | output | WORD_W | Captured word presented to channel A |
| chan_b_word | output | WORD_W | Captured word presented to channel B |
| latch_stb | output | 1 | One-cycle pulse after each capture |
| chan_a_rpt_vld | input | 1 | Channel A report valid |
| chan_a_rpt | input | WORD_W | Word read back by channel A |
| chan_b_rpt_vld | input | 1 | Channel B report valid |
| chan_b_rpt | input | WORD_W | Word read back by channel B |
| busy | output | 1 | Waiting for channel reports |
| agree_vld | output | 1 | One-cycle pulse: agreed word available |
| agree_word | output | WORD_W | Agreed sample word |
| safe_trip | output | 1 | Sticky fail-safe trip |

## Verification
The capture, `busy` and `latch_stb` are due one edge after the request. A report becomes held one edge after its valid cycle. The comparison result (agreement pulse, recapture strobe or trip) is due one edge after the second report is held. The bench drives inputs just after a falling edge and samples just before the next falling edge. Each check therefore lands in the exact cycle its result is due. It also checks in the following cycle that every pulse has dropped.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

    localparam int unsigned DEF_WORD_W    = 16;
    localparam int unsigned DEF_MAX_FAILS = 5;
    localparam int unsigned NUM_CHAN      = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_TRIP = 2'd2
    } seq_state_e;

    // Control from the sequencer to the capture register and report holders
    typedef struct packed {
        logic load;   // capture the selected input word
        logic clear;  // drop both held reports
    } seq_ctl_t;

    function automatic int unsigned fail_cnt_w(input int unsigned max_fails);
        return (max_fails < 2) ? 1 : $clog2(max_fails + 1);
    endfunction

endpackage

// File: rtl/dsa_sample_latch.sv
module dsa_sample_latch
    import dsa_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              use_pattern,
    input  logic [WORD_W-1:0] field_word,
    input  logic [WORD_W-1:0] pattern_word,
    output logic [WORD_W-1:0] word,
    output logic              strobe
);

    logic [WORD_W-1:0] src_word;

    always_comb begin
        src_word = use_pattern ? pattern_word : field_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word   <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= load;
            if (load) begin
                word <= src_word;
            end
        end
    end

    // R4
    no_stray_load_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(word));

endmodule

// File: rtl/dsa_report_capture.sv
module dsa_report_capture
    import dsa_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              clear,
    input  logic              rpt_vld,
    input  logic [WORD_W-1:0] rpt_word,
    output logic              held,
    output logic [WORD_W-1:0] word
);

    logic take;

    always_comb begin
        take = arm && rpt_vld && !held;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b0;
            word <= '0;
        end else if (clear) begin
            held <= 1'b0;
        end else if (take) begin
            held <= 1'b1;
            word <= rpt_word;
        end
    end

    // R5
    idle_report_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!arm && !clear) |=> ($stable(held) && $stable(word)));

    // R5
    first_report_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (held && !clear) |=> $stable(word));

endmodule

// File: rtl/dsa_retry_ctrl.sv
module dsa_retry_ctrl
    import dsa_pkg::*;
#(
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned MAX_FAILS = DEF_MAX_FAILS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_req,
    input  logic [NUM_CHAN-1:0] held,
    input  logic [WORD_W-1:0]   word_a,
    input  logic [WORD_W-1:0]   word_b,
    output seq_ctl_t            ctl,
    output logic                busy,
    output logic                safe_trip,
    output logic                agree_vld,
    output logic [WORD_W-1:0]   agree_word
);

    localparam int unsigned      CNT_W    = fail_cnt_w(MAX_FAILS);
    localparam logic [CNT_W-1:0] LAST_TRY = CNT_W'(MAX_FAILS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_FAILS);

    seq_state_e       state;
    logic [CNT_W-1:0] fails;
    logic             both;
    logic             same;
    logic             final_miss;

    always_comb begin
        both       = &held;
        same       = (word_a == word_b);
        final_miss = (fails == LAST_TRY);
        ctl.clear  = (state == SEQ_WAIT) && both;
        ctl.load   = ((state == SEQ_IDLE) && sample_req) ||
                     (ctl.clear && !same && !final_miss);
        busy       = (state == SEQ_WAIT);
        safe_trip  = (state == SEQ_TRIP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEQ_IDLE;
            fails      <= '0;
            agree_vld  <= 1'b0;
            agree_word <= '0;
        end else begin
            agree_vld <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (sample_req) begin
                        state <= SEQ_WAIT;
                    end
                end
                SEQ_WAIT: begin
                    if (both) begin
                        if (same) begin
                            agree_vld  <= 1'b1;
                            agree_word <= word_a;
                            fails      <= '0;
                            state      <= SEQ_IDLE;
                        end else begin
                            fails <= fails + 1'b1;
                            if (final_miss) begin
                                state <= SEQ_TRIP;
                            end
                        end
                    end
                end
                SEQ_TRIP: begin
                    state <= SEQ_TRIP;
                end
                default: begin
                    state <= SEQ_TRIP;
                end
            endcase
        end
    end

    // R6
    agree_single_chk: assert property (@(posedge clk) disable iff (rst)
        agree_vld |=> !agree_vld);

    // R9
    trip_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        safe_trip |=> safe_trip);

    // R8
    fail_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fails <= CNT_MAX);

    // R8
    no_agree_tripped_chk: assert property (@(posedge clk) disable iff (rst)
        safe_trip |-> !agree_vld);

    // R5
    wait_both_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !both) |=> !agree_vld);

endmodule

// File: rtl/dual_sample_agree.sv
module dual_sample_agree
    import dsa_pkg::*;
#(
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned MAX_FAILS = DEF_MAX_FAILS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_req,
    input  logic              selftest_en,
    input  logic [WORD_W-1:0] field_word,
    input  logic [WORD_W-1:0] selftest_word,
    output logic [WORD_W-1:0] chan_a_word,
    output logic [WORD_W-1:0] chan_b_word,
    output logic              latch_stb,
    input  logic              chan_a_rpt_vld,
    input  logic [WORD_W-1:0] chan_a_rpt,
    input  logic              chan_b_rpt_vld,
    input  logic [WORD_W-1:0] chan_b_rpt,
    output logic              busy,
    output logic              agree_vld,
    output logic [WORD_W-1:0] agree_word,
    output logic              safe_trip
);

    seq_ctl_t                         ctl;
    logic [WORD_W-1:0]                shared_word;
    logic [NUM_CHAN-1:0]              rpt_vld_v;
    logic [NUM_CHAN-1:0]              held_v;
    logic [NUM_CHAN-1:0][WORD_W-1:0]  rpt_word_v;
    logic [NUM_CHAN-1:0][WORD_W-1:0]  cap_word_v;

    always_comb begin
        rpt_vld_v     = {chan_b_rpt_vld, chan_a_rpt_vld};
        rpt_word_v[0] = chan_a_rpt;
        rpt_word_v[1] = chan_b_rpt;
        chan_a_word   = shared_word;
        chan_b_word   = shared_word;
    end

    dsa_sample_latch #(.WORD_W(WORD_W)) u_latch (
        .clk          (clk),
        .rst          (rst),
        .load         (ctl.load),
        .use_pattern  (selftest_en),
        .field_word   (field_word),
        .pattern_word (selftest_word),
        .word         (shared_word),
        .strobe       (latch_stb)
    );

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        dsa_report_capture #(.WORD_W(WORD_W)) u_cap (
            .clk      (clk),
            .rst      (rst),
            .arm      (busy),
            .clear    (ctl.clear),
            .rpt_vld  (rpt_vld_v[c]),
            .rpt_word (rpt_word_v[c]),
            .held     (held_v[c]),
            .word     (cap_word_v[c])
        );
    end

    dsa_retry_ctrl #(.WORD_W(WORD_W), .MAX_FAILS(MAX_FAILS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sample_req (sample_req),
        .held       (held_v),
        .word_a     (cap_word_v[0]),
        .word_b     (cap_word_v[1]),
        .ctl        (ctl),
        .busy       (busy),
        .safe_trip  (safe_trip),
        .agree_vld  (agree_vld),
        .agree_word (agree_word)
    );

    // R2
    strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
        latch_stb |-> busy);

endmodule

// File: tb/dual_sample_agree_tb.sv
`timescale 1ns/1ps
module dual_sample_agree_tb;

    localparam int W = 16;

    typedef struct packed {
        logic [15:0] ext;
        logic        sel;
        logic [15:0] pat;
        logic [15:0] flip;
        logic [2:0]  nbad;
    } vec_t;

    // field word, self-test select, pattern, B-report corruption, mismatching rounds
    localparam vec_t VECS [6] = '{
        '{16'hA5C3, 1'b0, 16'h0000, 16'h0001, 3'd0},
        '{16'h0000, 1'b0, 16'h0000, 16'h0001, 3'd0},
        '{16'hFFFF, 1'b0, 16'h0000, 16'h8000, 3'd1},
        '{16'h1234, 1'b1, 16'h5A5A, 16'h0010, 3'd0},
        '{16'h0F0F, 1'b1, 16'hC3C3, 16'hFFFF, 3'd2},
        '{16'h7FFE, 1'b0, 16'h0000, 16'h0100, 3'd4}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sample_req = 1'b0;
    logic         selftest_en = 1'b0;
    logic [W-1:0] field_word = '0;
    logic [W-1:0] selftest_word = '0;
    logic [W-1:0] chan_a_word, chan_b_word;
    logic         latch_stb;
    logic         chan_a_rpt_vld = 1'b0;
    logic [W-1:0] chan_a_rpt = '0;
    logic         chan_b_rpt_vld = 1'b0;
    logic [W-1:0] chan_b_rpt = '0;
    logic         busy, agree_vld, safe_trip;
    logic [W-1:0] agree_word;

    int n_chk = 0;
    int n_fail = 0;
    logic [W-1:0] last_word = '0;

    always #10 clk = ~clk;

    dual_sample_agree #(.WORD_W(W), .MAX_FAILS(5)) u_dut (
        .clk(clk), .rst(rst), .sample_req(sample_req), .selftest_en(selftest_en),
        .field_word(field_word), .selftest_word(selftest_word),
        .chan_a_word(chan_a_word), .chan_b_word(chan_b_word), .latch_stb(latch_stb),
        .chan_a_rpt_vld(chan_a_rpt_vld), .chan_a_rpt(chan_a_rpt),
        .chan_b_rpt_vld(chan_b_rpt_vld), .chan_b_rpt(chan_b_rpt),
        .busy(busy), .agree_vld(agree_vld), .agree_word(agree_word), .safe_trip(safe_trip)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // One full sample exchange: nbad mismatching rounds, then agreement.
    // With nbad of 5 the fifth mismatch trips instead.
    task automatic run_read(input logic [W-1:0] ext, input logic sel, input logic [W-1:0] pat,
                            input logic [W-1:0] flip, input int nbad);
        logic [W-1:0] ext_cur;
        logic [W-1:0] exp_w;
        logic         mism;
        ext_cur = ext;
        field_word = ext; selftest_en = sel; selftest_word = pat; sample_req = 1'b1;
        @(negedge clk);
        sample_req = 1'b0;
        for (int r = 0; r <= nbad && r < 5; r++) begin
            exp_w = sel ? pat : ext_cur;
            mism  = (r < nbad);
            chk(sel ? "R3 chan_a self-test word" : "R2 chan_a word", chan_a_word, exp_w);
            chk("R2 chan_b word", chan_b_word, exp_w);
            chk(r == 0 ? "R2 latch_stb" : "R7 recapture latch_stb", latch_stb, 1'b1);
            chk("R2 busy", busy, 1'b1);
            last_word = exp_w;
            chan_a_rpt_vld = 1'b1; chan_a_rpt = exp_w;
            chan_b_rpt_vld = 1'b1; chan_b_rpt = mism ? (exp_w ^ flip) : exp_w;
            @(negedge clk);
            chan_a_rpt_vld = 1'b0; chan_b_rpt_vld = 1'b0;
            chk("R5 no result while held", agree_vld, 1'b0);
            chk("R2 latch_stb single", latch_stb, 1'b0);
            if (mism) begin
                ext_cur = ext + W'(r + 1);
                field_word = ext_cur;
                @(negedge clk);
                chk("R7 no agree on mismatch", agree_vld, 1'b0);
                if (r == 4) begin
                    chk("R8 trip on fifth mismatch", safe_trip, 1'b1);
                    chk("R8 busy low after trip", busy, 1'b0);
                    chk("R8 no recapture on trip", latch_stb, 1'b0);
                end else begin
                    chk("R8 R10 no early trip", safe_trip, 1'b0);
                    chk("R7 busy kept", busy, 1'b1);
                end
            end else begin
                @(negedge clk);
                chk("R6 agree_vld", agree_vld, 1'b1);
                chk("R6 agree_word", agree_word, exp_w);
                chk("R6 busy dropped", busy, 1'b0);
                chk("R10 no trip", safe_trip, 1'b0);
                @(negedge clk);
                chk("R6 agree_vld single", agree_vld, 1'b0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 chan_a after reset", chan_a_word, '0);
        chk("R1 chan_b after reset", chan_b_word, '0);
        chk("R1 latch_stb after reset", latch_stb, 1'b0);
        chk("R1 busy after reset", busy, 1'b0);
        chk("R1 agree_vld after reset", agree_vld, 1'b0);
        chk("R1 safe_trip after reset", safe_trip, 1'b0);

        for (int i = 0; i < 6; i++) begin
            run_read(VECS[i].ext, VECS[i].sel, VECS[i].pat, VECS[i].flip, int'(VECS[i].nbad));
        end

        // R10: a second run of four mismatches after agreement must not trip
        run_read(16'h3C3C, 1'b0, 16'h0000, 16'h0002, 4);

        // R4: request while busy is ignored
        field_word = 16'h1111; selftest_en = 1'b0; sample_req = 1'b1;
        @(negedge clk);
        field_word = 16'h2222;
        @(negedge clk);
        sample_req = 1'b0;
        chk("R4 busy request ignored word", chan_a_word, 16'h1111);
        chk("R4 busy request no strobe", latch_stb, 1'b0);

        // R5: reports in separate cycles, second report from A ignored
        chan_a_rpt_vld = 1'b1; chan_a_rpt = 16'h1111;
        @(negedge clk);
        chan_a_rpt = 16'h9999;
        @(negedge clk);
        chan_a_rpt_vld = 1'b0;
        chk("R5 waiting for B", agree_vld, 1'b0);
        chk("R5 still busy", busy, 1'b1);
        chan_b_rpt_vld = 1'b1; chan_b_rpt = 16'h1111;
        @(negedge clk);
        chan_b_rpt_vld = 1'b0;
        chk("R5 compare one edge later", agree_vld, 1'b0);
        @(negedge clk);
        chk("R5 agree with first A report", agree_vld, 1'b1);
        chk("R5 agree_word", agree_word, 16'h1111);

        // R5: report while idle is ignored
        chan_a_rpt_vld = 1'b1; chan_a_rpt = 16'hDEAD;
        @(negedge clk);
        chan_a_rpt_vld = 1'b0;
        field_word = 16'h4444; sample_req = 1'b1;
        @(negedge clk);
        sample_req = 1'b0;
        chan_b_rpt_vld = 1'b1; chan_b_rpt = 16'h4444;
        @(negedge clk);
        chan_b_rpt_vld = 1'b0;
        @(negedge clk);
        chk("R5 idle report not held", agree_vld, 1'b0);
        chk("R5 busy without A", busy, 1'b1);
        chan_a_rpt_vld = 1'b1; chan_a_rpt = 16'h4444;
        @(negedge clk);
        chan_a_rpt_vld = 1'b0;
        @(negedge clk);
        chk("R5 agree after late A", agree_vld, 1'b1);
        chk("R5 agree_word late A", agree_word, 16'h4444);

        // R8: five consecutive mismatches trip
        run_read(16'h6000, 1'b0, 16'h0000, 16'h0400, 5);

        // R9: sticky, requests and reports ignored
        field_word = 16'hBEEF; sample_req = 1'b1;
        chan_a_rpt_vld = 1'b1; chan_b_rpt_vld = 1'b1;
        chan_a_rpt = 16'h0001; chan_b_rpt = 16'h0001;
        @(negedge clk);
        sample_req = 1'b0; chan_a_rpt_vld = 1'b0; chan_b_rpt_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 trip sticky", safe_trip, 1'b1);
        chk("R9 word unchanged after trip", chan_a_word, last_word);
        chk("R9 no strobe after trip", latch_stb, 1'b0);
        chk("R9 no agree after trip", agree_vld, 1'b0);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 reset clears trip", safe_trip, 1'b0);
        chk("R1 reset clears word", chan_a_word, '0);

        // R1: failure count cleared, four mismatches then agreement is fine
        run_read(16'h0101, 1'b0, 16'h0000, 16'h0001, 4);

        summary();
        $finish;
    end

endmodule